// File: doc/BRIEF.md
# Multi-Phase Synchronous Serial Receiver

This block receives serial frames whose bit timing comes from an external serial clock that has no fixed phase relation to the system clock. Both the external clock and the data line pass through the same synchronizer into the system domain. Each low-to-high transition of the synchronized clock becomes a pulse one system cycle long. That pulse starts a two-step shift. A shift-out step runs in the second half of the pulse cycle. After two idle half cycles, a separate shift-in step runs at the start of a later cycle.

Half-cycle resolution comes from running the block on `clk_i`, a clock at twice the system rate. One system cycle is two `clk_i` periods, and a free-running phase bit marks which half is current. Because of the idle gap, every bit needs at least three system cycles. If external clock edges come faster than that, each new pulse cancels the pending shift-in, so the received state never changes. The frame logic assembles start, data and stop bits into a holding register. It reports three flags: a busy flag, a byte-ready flag that only software can clear, and a stop-window flag.

Top module: `sync_serial_rx`

## Requirements
- R1: While `rst_ni` is low, `rx_byte_o` is 0 and `busy_o`, `ready_o` and `stop_win_o` are 0. The byte-ready enable is also 0.
- R2: The clock and data inputs are sampled once per system cycle through two stages. Each low-to-high transition of the sampled clock yields exactly one bit, however long the clock then stays high.
- R3: A shift-out step runs in the second half of the pulse cycle. The shift-in step runs three half cycles later, in the first half of a cycle, and the two never overlap. Received state changes only on a shift-in, which falls at least 3.5 system cycles after the clock transition is presented.
- R4: Any external clock period of three system cycles or more receives correctly, for any split between low time and high time of at least one system cycle each.
- R5: With an external clock period of two system cycles, no shift-in occurs while the edges keep arriving. `busy_o`, `rx_byte_o`, `ready_o` and `stop_win_o` keep their values.
- R6: A frame is one start bit (0), eight data bits with the least significant bit first, and one stop bit (1). A valid stop bit loads the assembled byte into `rx_byte_o`.
- R7: `busy_o` goes high at the shift-in of a start bit, while the data bits are still arriving. It goes low at the shift-in of the stop bit.
- R8: When the enable is 1, a loaded byte sets `ready_o`. `ready_o` stays set through later bytes, because no read clears it.
- R9: Writing 0 to the enable (`ien_we_i` with `ien_i` = 0) clears `ready_o` and holds it clear. Writing 1 does not set `ready_o`; the next loaded byte does.
- R10: `stop_win_o` goes high when a byte is loaded and goes low at the shift-in of the next start bit. It is never high together with `busy_o`.
- R11: A stop bit of 0 discards the frame. `rx_byte_o` is unchanged, `ready_o` and `stop_win_o` are not set, and `busy_o` returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock; two periods form one system cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | External serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, valid at the rising edge of sclk_i |
| ien_we_i | input | 1 | Write strobe for the byte-ready enable |
| ien_i | input | 1 | Enable value written on ien_we_i |
| rx_byte_o | output | DATA_W | Last correctly framed byte |
| busy_o | output | 1 | Frame reception in progress |
| ready_o | output | 1 | Byte-ready interrupt flag |
| stop_win_o | output | 1 | Byte complete, no new start bit yet |

## Verification
Frames are sent at exactly three system cycles per bit with both low/high splits, which separates a correct shift pipeline from one whose shift-in lands one half cycle late or early. Randomly chosen periods from three to six cycles and long high phases show that every edge yields exactly one bit. A burst at two cycles per bit must leave every output frozen, which tells a cancelling controller apart from one that still shifts. Enable writes between frames, and a frame with a zero stop bit, separate the flag update rules from the byte-load path.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;
  // half-cycle steps counted from the start of the pulse cycle
  localparam int unsigned SO_STEP = 1;
  localparam int unsigned SI_STEP = SO_STEP + 3;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_DATA,
    FR_STOP
  } fr_state_e;
endpackage

// File: rtl/ssr_sync.sv
`timescale 1ns/1ps
module ssr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic pulse_o,
  output logic data_o
);
  // bit 0: clock, bit 1: data, sampled together
  logic [STAGES-1:0][1:0] chain_q;
  logic                   clk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q    <= '1;
      clk_prev_q <= 1'b1;
    end else if (adv_i) begin
      chain_q[0] <= {sdata_i, sclk_i};
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      clk_prev_q <= chain_q[STAGES-1][0];
    end
  end

  assign pulse_o = chain_q[STAGES-1][0] & ~clk_prev_q;
  assign data_o  = chain_q[STAGES-1][1];

  a_r2_pulse_spans_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && !adv_i) |=> pulse_o);
  a_r2_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && adv_i) |=> !pulse_o);
endmodule

// File: rtl/ssr_shift_ctl.sv
`timescale 1ns/1ps
module ssr_shift_ctl
  import ssr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_i,   // 0: first half of system cycle
  input  logic pulse_i,
  input  logic data_i,
  output logic si_o,
  output logic bit_o
);
  localparam int unsigned SEQ_W = $clog2(SI_STEP + 1);

  logic [SEQ_W-1:0] step_q;
  logic             so;
  logic             bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
    end else if (pulse_i && !phase_i) begin
      step_q <= SEQ_W'(SO_STEP);   // new edge restarts the sequence
    end else if (step_q != '0) begin
      step_q <= (step_q == SEQ_W'(SI_STEP)) ? '0 : step_q + 1'b1;
    end
  end

  assign so = (step_q == SEQ_W'(SO_STEP));
  // a fresh pulse in the transfer half cancels the transfer
  assign si_o = (step_q == SEQ_W'(SI_STEP)) && !pulse_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  bit_q <= 1'b1;
    else if (so)  bit_q <= data_i;
  end

  assign bit_o = bit_q;

  a_r3_out_mid_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so |-> phase_i);
  a_r3_in_cycle_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    si_o |-> !phase_i);
  a_r3_in_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    si_o |-> $past(so, 3));
  a_r3_gap_after_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so |=> !si_o);
endmodule

// File: rtl/ssr_frame.sv
`timescale 1ns/1ps
module ssr_frame
  import ssr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              si_i,
  input  logic              bit_i,
  input  logic              ien_we_i,
  input  logic              ien_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic              stop_win_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  fr_state_e         state_q;
  logic [DATA_W-1:0] shreg_q, rx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, win_q, ien_q, ready_q;
  logic              byte_done;

  assign byte_done = si_i && (state_q == FR_STOP) && bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_IDLE;
      shreg_q <= '0;
      rx_q    <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      win_q   <= 1'b0;
    end else if (si_i) begin
      unique case (state_q)
        FR_IDLE: if (!bit_i) begin
          state_q <= FR_DATA;
          busy_q  <= 1'b1;
          win_q   <= 1'b0;
          cnt_q   <= '0;
        end
        FR_DATA: begin
          shreg_q <= {bit_i, shreg_q[DATA_W-1:1]};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) state_q <= FR_STOP;
        end
        FR_STOP: begin
          state_q <= FR_IDLE;
          busy_q  <= 1'b0;
          if (bit_i) begin
            rx_q  <= shreg_q;
            win_q <= 1'b1;
          end
        end
        default: state_q <= FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      if (ien_we_i) ien_q <= ien_i;
      if (ien_we_i && !ien_i)      ready_q <= 1'b0;
      else if (byte_done && ien_q) ready_q <= 1'b1;
    end
  end

  assign rx_byte_o  = rx_q;
  assign busy_o     = busy_q;
  assign ready_o    = ready_q;
  assign stop_win_o = win_q;

  a_r7_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(si_i && !bit_i));
  a_r8_ready_on_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(si_i && bit_i));
  a_r9_ready_clear_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(ien_we_i && !ien_i));
  a_r10_win_busy_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && stop_win_o));
  a_r11_byte_only_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_byte_o) |-> $past(si_i && bit_i));
endmodule

// File: rtl/sync_serial_rx.sv
`timescale 1ns/1ps
module sync_serial_rx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              ien_we_i,
  input  logic              ien_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic              stop_win_o
);
  logic phase_q;   // 0: first half, 1: second half of system cycle
  logic pulse, sdata_s, si, bit_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  ssr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (phase_q),
    .sclk_i  (sclk_i),
    .sdata_i (sdata_i),
    .pulse_o (pulse),
    .data_o  (sdata_s)
  );

  ssr_shift_ctl u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase_q),
    .pulse_i (pulse),
    .data_i  (sdata_s),
    .si_o    (si),
    .bit_o   (bit_s)
  );

  ssr_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .si_i       (si),
    .bit_i      (bit_s),
    .ien_we_i   (ien_we_i),
    .ien_i      (ien_i),
    .rx_byte_o  (rx_byte_o),
    .busy_o     (busy_o),
    .ready_o    (ready_o),
    .stop_win_o (stop_win_o)
  );
endmodule

// File: tb/sync_serial_rx_test.sv
`timescale 1ns/1ps
module sync_serial_rx_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk_i = 1'b1;
  logic       sdata_i = 1'b1;
  logic       ien_we_i = 1'b0;
  logic       ien_i = 1'b0;
  logic [7:0] rx_byte_o;
  logic       busy_o, ready_o, stop_win_o;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] exp_byte = 8'h00;
  logic       exp_ready = 1'b0;
  logic       exp_ien = 1'b0;

  always #2.5 clk_i = ~clk_i;   // 200 MHz double-rate clock

  sync_serial_rx uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .ien_we_i(ien_we_i), .ien_i(ien_i), .rx_byte_o(rx_byte_o),
    .busy_o(busy_o), .ready_o(ready_o), .stop_win_o(stop_win_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one system cycle = two clk_i periods
  task automatic sys_wait(input int n);
    repeat (2 * n) @(negedge clk_i);
  endtask

  function automatic logic ready_after_byte(input logic cur, input logic en);
    return cur | en;
  endfunction

  task automatic write_ien(input logic v);
    @(negedge clk_i);
    ien_we_i = 1'b1; ien_i = v;
    @(negedge clk_i);
    ien_we_i = 1'b0;
    exp_ien = v;
    if (!v) exp_ready = 1'b0;
  endtask

  task automatic send_bit(input logic b, input int lo, input int hi);
    sclk_i = 1'b0; sdata_i = b;
    sys_wait(lo);
    sclk_i = 1'b1;
    sys_wait(hi);
  endtask

  // mid: check busy/stop-window after start + 4 data bits
  task automatic send_frame(input logic [7:0] v, input int lo, input int hi,
                            input logic stop, input bit mid, input logic mid_busy);
    send_bit(1'b0, lo, hi);
    for (int i = 0; i < 8; i++) begin
      send_bit(v[i], lo, hi);
      if (mid && i == 3) begin
        check(mid_busy ? "R7" : "R5", "busy mid-frame", busy_o, mid_busy);
        if (mid_busy) check("R10", "stop window mid-frame", stop_win_o, 1'b0);
      end
    end
    send_bit(stop, lo, hi);
  endtask

  task automatic idle_gap();
    sdata_i = 1'b1; sclk_i = 1'b1;
    sys_wait(8);
  endtask

  task automatic good_frame(input logic [7:0] v, input int lo, input int hi,
                            input string req);
    send_frame(v, lo, hi, 1'b1, 1'b0, 1'b0);
    idle_gap();
    exp_byte  = v;
    exp_ready = ready_after_byte(exp_ready, exp_ien);
    check(req, "received byte", rx_byte_o, exp_byte);
    check("R8", "ready flag", ready_o, exp_ready);
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    sys_wait(4);
    check("R1", "rx_byte in reset", rx_byte_o, 8'h00);
    check("R1", "busy in reset", busy_o, 1'b0);
    check("R1", "ready in reset", ready_o, 1'b0);
    check("R1", "stop window in reset", stop_win_o, 1'b0);
    rst_ni = 1'b1;
    sys_wait(2);

    // R1: enable resets to 0, so a byte must not set ready
    good_frame(8'h11, 1, 2, "R1");
    check("R1", "ready with reset enable", ready_o, 1'b0);

    write_ien(1'b1);

    // R3: output must not change 2 system cycles after the stop edge
    send_frame(8'hA5, 1, 2, 1'b1, 1'b0, 1'b0);
    check("R3", "byte not yet shifted in", rx_byte_o, 8'h11);
    check("R3", "ready not yet set", ready_o, 1'b0);
    idle_gap();
    exp_byte = 8'hA5; exp_ready = 1'b1;
    check("R6", "byte at period 3 (1/2)", rx_byte_o, 8'hA5);
    check("R8", "ready after byte", ready_o, 1'b1);
    check("R10", "stop window after byte", stop_win_o, 1'b1);
    check("R7", "busy after stop", busy_o, 1'b0);

    // R7, R10: mid-frame flags at period 3 (2/1)
    send_frame(8'h3C, 2, 1, 1'b1, 1'b1, 1'b1);
    idle_gap();
    check("R4", "byte at period 3 (2/1)", rx_byte_o, 8'h3C);
    check("R8", "ready stays set", ready_o, 1'b1);
    check("R10", "stop window set again", stop_win_o, 1'b1);
    exp_byte = 8'h3C;

    // R2: long high phase yields a single bit per edge
    good_frame(8'h96, 1, 6, "R2");

    // R4: random periods 3..6 with random split
    for (int k = 0; k < 16; k++) begin
      logic [7:0] v;
      int lo, hi;
      v  = 8'($urandom);
      lo = 1 + int'($urandom % 3);
      hi = (lo == 1) ? 2 + int'($urandom % 2) : 1 + int'($urandom % 3);
      good_frame(v, lo, hi, "R4");
    end

    // R9: clear and re-arm
    write_ien(1'b0);
    sys_wait(1);
    check("R9", "ready cleared by enable write 0", ready_o, 1'b0);
    send_frame(8'h5A, 2, 2, 1'b1, 1'b0, 1'b0);
    idle_gap();
    check("R6", "byte with enable off", rx_byte_o, 8'h5A);
    check("R9", "ready held clear", ready_o, 1'b0);
    write_ien(1'b1);
    sys_wait(2);
    check("R9", "re-arm does not set ready", ready_o, 1'b0);
    send_frame(8'hC3, 2, 2, 1'b1, 1'b0, 1'b0);
    idle_gap();
    check("R9", "ready after re-armed byte", ready_o, 1'b1);
    check("R6", "byte after re-arm", rx_byte_o, 8'hC3);

    // R5: period 2 freezes everything
    send_frame(8'h00, 1, 1, 1'b1, 1'b1, 1'b0);
    idle_gap();
    check("R5", "byte frozen", rx_byte_o, 8'hC3);
    check("R5", "ready frozen", ready_o, 1'b1);
    check("R5", "stop window frozen", stop_win_o, 1'b1);
    check("R5", "busy frozen", busy_o, 1'b0);
    good_frame(8'h81, 2, 2, "R4");

    // R11: zero stop bit discards the frame
    write_ien(1'b0);
    write_ien(1'b1);
    send_frame(8'h7E, 2, 1, 1'b0, 1'b0, 1'b0);
    idle_gap();
    check("R11", "byte kept on bad stop", rx_byte_o, 8'h81);
    check("R11", "ready not set on bad stop", ready_o, 1'b0);
    check("R11", "stop window not set", stop_win_o, 1'b0);
    check("R11", "busy cleared", busy_o, 1'b0);
    exp_ready = 1'b0;
    good_frame(8'h24, 1, 2, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule